// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block decides, every cycle, how an eight-stage in-order pipeline (IF1, IF2, ID, EX1, EX2, MEM1, MEM2, WB) must move to stay correct. It reads a small descriptor for each stage: whether the slot is valid, its operation kind, and its destination or source register numbers. It also reads the write intent of WB and a misprediction flag raised when EX2 resolves a branch or jump. From these it produces a hold for the three front stages, a no-op insert behind ID, a four-wide flush of IF1 through EX1, operand forwarding selects for the ID/EX1 capture, and the grant of the single register-file port.

The register file has one port, so it can either be read or be written in a given cycle. A write from WB wins over a read from ID, and the front of the pipeline waits one cycle. A result can reach ID/EX1 only from the EX2/MEM1 or MEM2/WB pipeline registers. A consumer therefore waits when its producer is in EX1, or when its producer is a load that is still in EX2 or MEM1.

The block keeps one registered mark per stage that tags slots squashed by a flush. The mark follows the slot down the pipeline. A marked slot never causes a hazard, never forwards, never writes the register file and never raises a flush. Register number 255 means "no register" in every field.

Top module: `hzc_ctrl`

## Requirements
- R1: During and right after synchronous reset all squash marks are clear, and with idle inputs every control output is zero.
- R2: When WB is live and writing (valid, write set, not marked) and the active ID instruction reads at least one register, `hold_front_o` and `bubble_o` are 1, `rf_rd_en_o` is 0 and `rf_wr_en_o` is 1. An ID instruction that reads no register gives no hold and no read.
- R3: A live producer in EX1 whose destination equals a source read by ID causes hold and bubble, whatever its kind.
- R4: A matching load in EX2 causes hold and bubble. A matching non-load in EX2 causes no hold and selects forwarding code 1 (from EX2/MEM1) for that operand.
- R5: A matching load in MEM1 causes hold and bubble. A matching non-load in MEM1, or any matching producer in MEM2, selects forwarding code 2 (from MEM2/WB). Code 0 means the register file.
- R6: When several producers match one source, the EX2 match is selected over the MEM1 and MEM2 matches.
- R7: Register 255 in a source or destination field never matches, never counts as a read and never stalls.
- R8: Kind codes are 0 idle, 1 register-register ALU, 2 immediate ALU, 3 load, 4 store, 5 branch, 6 jump, 7 system, 8 jump-register. Source A is read by kinds 1,2,3,4,5,8 and source B by kinds 1,4,5. Only kinds 1,2,3 write a destination. Sources a kind does not read and destinations it does not write are ignored.
- R9: A mispredict flag on a valid, unmarked EX2 slot drives `flush_o` to 4'b1111 (bit 0 is IF1 through bit 3 EX1). In that cycle hold and bubble are 0, even when a hazard is present.
- R10: `squash_mark_o` has bit i for stage i (0 IF1 … 7 WB). A flush sets bits 1..4 in the next cycle. The marks then shift one stage per cycle, IF1 enters unmarked, and a held front keeps the marks of IF2 and ID. A marked ID raises no hazard or read, a marked WB does not write, and a marked EX2 does not flush.
- R11: Invalid producer stages and an invalid ID slot never cause a match, a stall or a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | ID slot holds an instruction |
| id_kind | input | 4 | ID operation kind |
| id_src_a | input | REG_W | ID first source register |
| id_src_b | input | REG_W | ID second source register |
| ex1_valid | input | 1 | EX1 slot valid |
| ex1_kind | input | 4 | EX1 operation kind |
| ex1_dst | input | REG_W | EX1 destination |
| ex2_valid | input | 1 | EX2 slot valid |
| ex2_kind | input | 4 | EX2 operation kind |
| ex2_dst | input | REG_W | EX2 destination |
| ex2_mispredict | input | 1 | EX2 found a wrong prediction |
| mem1_valid | input | 1 | MEM1 slot valid |
| mem1_kind | input | 4 | MEM1 operation kind |
| mem1_dst | input | REG_W | MEM1 destination |
| mem2_valid | input | 1 | MEM2 slot valid |
| mem2_kind | input | 4 | MEM2 operation kind |
| mem2_dst | input | REG_W | MEM2 destination |
| wb_valid | input | 1 | WB slot valid |
| wb_wr | input | 1 | WB wants to write the register file |
| hold_front_o | output | 1 | IF1, IF2 and ID keep their contents |
| bubble_o | output | 1 | A no-op enters the slot behind ID |
| flush_o | output | 4 | Squash IF1..EX1 (bit 0 IF1) |
| fwd_a_o | output | 2 | Source A select: 0 file, 1 EX2/MEM1, 2 MEM2/WB |
| fwd_b_o | output | 2 | Source B select, same codes |
| rf_rd_en_o | output | 1 | Register-file port granted to ID |
| rf_wr_en_o | output | 1 | Register-file port granted to WB |
| squash_mark_o | output | 8 | Per-stage squashed tag |

## Verification
If the squash marks go wrong, the fault shows within one cycle of a flush on `squash_mark_o`. It also shows later, when a squashed slot reaches WB and `rf_wr_en_o` rises where it must stay low, or when a squashed ID slot still raises a hold. A wrong producer-distance decision shows in the same cycle as a hold that is missing or extra, or as a wrong forwarding code. The bench therefore drives each producer position with load and non-load kinds and follows one flush until its four marks have left WB.

// File: rtl/hzc_pkg.sv
`timescale 1ns/1ps
package hzc_pkg;

    // Stage positions; the squash-mark vector and flush vector rely on this order.
    localparam int STG_IF1  = 0;
    localparam int STG_IF2  = 1;
    localparam int STG_ID   = 2;
    localparam int STG_EX1  = 3;
    localparam int STG_EX2  = 4;
    localparam int STG_MEM1 = 5;
    localparam int STG_MEM2 = 6;
    localparam int STG_WB   = 7;
    localparam int NUM_STG  = 8;

    // Producers checked against ID: EX1, EX2, MEM1, MEM2 (index 0..3).
    localparam int NUM_PROD  = STG_MEM2 - STG_EX1 + 1;
    localparam int NUM_SRC   = 2;
    localparam int FLUSH_N   = STG_EX2 - STG_IF1;
    localparam int KIND_W    = 4;

    typedef enum logic [KIND_W-1:0] {
        K_IDLE     = 4'd0,
        K_ALU_RR   = 4'd1,
        K_ALU_IMM  = 4'd2,
        K_LOAD     = 4'd3,
        K_STORE    = 4'd4,
        K_BRANCH   = 4'd5,
        K_JUMP     = 4'd6,
        K_SYS      = 4'd7,
        K_JUMP_REG = 4'd8
    } op_kind_e;

    typedef enum logic [1:0] {
        FWD_RF    = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic live;
        logic load;
    } prod_flags_t;

    function automatic logic kind_reads_a(input logic [KIND_W-1:0] k);
        case (k)
            K_ALU_RR, K_ALU_IMM, K_LOAD, K_STORE, K_BRANCH, K_JUMP_REG: kind_reads_a = 1'b1;
            default: kind_reads_a = 1'b0;
        endcase
    endfunction

    function automatic logic kind_reads_b(input logic [KIND_W-1:0] k);
        case (k)
            K_ALU_RR, K_STORE, K_BRANCH: kind_reads_b = 1'b1;
            default: kind_reads_b = 1'b0;
        endcase
    endfunction

    function automatic logic kind_writes(input logic [KIND_W-1:0] k);
        case (k)
            K_ALU_RR, K_ALU_IMM, K_LOAD: kind_writes = 1'b1;
            default: kind_writes = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hzc_producer.sv
`timescale 1ns/1ps
module hzc_producer
    import hzc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic [REG_W-1:0]  dst,
    input  logic              squashed,
    output prod_flags_t       flags
);
    localparam logic [REG_W-1:0] NO_REG = '1;

    always_comb begin
        flags.live = valid && !squashed && kind_writes(kind) && (dst != NO_REG);
        flags.load = (kind == K_LOAD);
    end
endmodule

// File: rtl/hzc_src_check.sv
`timescale 1ns/1ps
module hzc_src_check
    import hzc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                             used,
    input  logic [REG_W-1:0]                 src,
    input  prod_flags_t [NUM_PROD-1:0]       prod,
    input  logic [NUM_PROD-1:0][REG_W-1:0]   prod_dst,
    output logic                             stall,
    output fwd_sel_e                         fwd
);
    localparam int P_EX1  = STG_EX1  - STG_EX1;
    localparam int P_EX2  = STG_EX2  - STG_EX1;
    localparam int P_MEM1 = STG_MEM1 - STG_EX1;
    localparam int P_MEM2 = STG_MEM2 - STG_EX1;

    logic [NUM_PROD-1:0] hit;

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_hit
        assign hit[p] = used && prod[p].live && (prod_dst[p] == src);
    end

    always_comb begin
        stall = hit[P_EX1]
             || (hit[P_EX2]  && prod[P_EX2].load)
             || (hit[P_MEM1] && prod[P_MEM1].load);
        if (hit[P_EX2] && !prod[P_EX2].load)
            fwd = FWD_EXMEM;
        else if ((hit[P_MEM1] && !prod[P_MEM1].load) || hit[P_MEM2])
            fwd = FWD_MEMWB;
        else
            fwd = FWD_RF;
    end
endmodule

// File: rtl/hzc_squash_track.sv
`timescale 1ns/1ps
module hzc_squash_track
    import hzc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               hold,
    output logic [NUM_STG-1:0] mark
);
    logic [NUM_STG-1:0] nxt;

    always_comb begin
        nxt = '0;
        if (flush) begin
            for (int i = STG_IF2; i <= STG_EX2; i++) nxt[i] = 1'b1;
            for (int i = STG_MEM1; i < NUM_STG; i++) nxt[i] = mark[i-1];
        end else if (hold) begin
            nxt[STG_IF2] = mark[STG_IF2];
            nxt[STG_ID]  = mark[STG_ID];
            nxt[STG_EX1] = 1'b0;
            for (int i = STG_EX2; i < NUM_STG; i++) nxt[i] = mark[i-1];
        end else begin
            for (int i = STG_IF2; i < NUM_STG; i++) nxt[i] = mark[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mark <= '0;
        else     mark <= nxt;
    end

    // R10: a flush leaves IF2..EX2 tagged in the next cycle
    p_flush_squashes_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (mark[STG_EX2:STG_IF2] == '1));

    // R10: a held front keeps its tags
    p_hold_keeps_front_r10: assert property (@(posedge clk) disable iff (rst)
        (hold && !flush) |=> (mark[STG_ID:STG_IF2] == $past(mark[STG_ID:STG_IF2])));

    // R3: the inserted no-op is a plain bubble, not a squashed slot
    p_bubble_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (hold && !flush) |=> !mark[STG_EX1]);
endmodule

// File: rtl/hzc_ctrl.sv
`timescale 1ns/1ps
module hzc_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               id_valid,
    input  logic [3:0]         id_kind,
    input  logic [REG_W-1:0]   id_src_a,
    input  logic [REG_W-1:0]   id_src_b,
    input  logic               ex1_valid,
    input  logic [3:0]         ex1_kind,
    input  logic [REG_W-1:0]   ex1_dst,
    input  logic               ex2_valid,
    input  logic [3:0]         ex2_kind,
    input  logic [REG_W-1:0]   ex2_dst,
    input  logic               ex2_mispredict,
    input  logic               mem1_valid,
    input  logic [3:0]         mem1_kind,
    input  logic [REG_W-1:0]   mem1_dst,
    input  logic               mem2_valid,
    input  logic [3:0]         mem2_kind,
    input  logic [REG_W-1:0]   mem2_dst,
    input  logic               wb_valid,
    input  logic               wb_wr,
    output logic               hold_front_o,
    output logic               bubble_o,
    output logic [3:0]         flush_o,
    output logic [1:0]         fwd_a_o,
    output logic [1:0]         fwd_b_o,
    output logic               rf_rd_en_o,
    output logic               rf_wr_en_o,
    output logic [7:0]         squash_mark_o
);
    localparam logic [REG_W-1:0] NO_REG = '1;

    logic [NUM_STG-1:0]                mark;
    logic [NUM_PROD-1:0]               p_valid;
    logic [NUM_PROD-1:0][KIND_W-1:0]   p_kind;
    logic [NUM_PROD-1:0][REG_W-1:0]    p_dst;
    prod_flags_t [NUM_PROD-1:0]        p_flags;
    logic [NUM_SRC-1:0]                s_used;
    logic [NUM_SRC-1:0][REG_W-1:0]     s_reg;
    logic [NUM_SRC-1:0]                s_stall;
    fwd_sel_e                          s_fwd [NUM_SRC];

    logic id_active, wb_live, id_reads, data_stall, port_stall, flush_req, hold;

    assign p_valid = {mem2_valid, mem1_valid, ex2_valid, ex1_valid};
    assign p_kind  = {mem2_kind,  mem1_kind,  ex2_kind,  ex1_kind};
    assign p_dst   = {mem2_dst,   mem1_dst,   ex2_dst,   ex1_dst};

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
        hzc_producer #(.REG_W(REG_W)) u_prod (
            .valid    (p_valid[p]),
            .kind     (p_kind[p]),
            .dst      (p_dst[p]),
            .squashed (mark[STG_EX1 + p]),
            .flags    (p_flags[p])
        );
    end

    assign id_active = id_valid && !mark[STG_ID];
    assign s_reg     = {id_src_b, id_src_a};
    assign s_used[0] = id_active && kind_reads_a(id_kind) && (id_src_a != NO_REG);
    assign s_used[1] = id_active && kind_reads_b(id_kind) && (id_src_b != NO_REG);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzc_src_check #(.REG_W(REG_W)) u_chk (
            .used     (s_used[s]),
            .src      (s_reg[s]),
            .prod     (p_flags),
            .prod_dst (p_dst),
            .stall    (s_stall[s]),
            .fwd      (s_fwd[s])
        );
    end

    assign id_reads   = |s_used;
    assign wb_live    = wb_valid && wb_wr && !mark[STG_WB];
    assign data_stall = |s_stall;
    assign port_stall = wb_live && id_reads;
    assign flush_req  = ex2_valid && ex2_mispredict && !mark[STG_EX2];
    assign hold       = !flush_req && (data_stall || port_stall);

    hzc_squash_track u_track (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_req),
        .hold  (hold),
        .mark  (mark)
    );

    assign hold_front_o  = hold;
    assign bubble_o      = hold;
    assign flush_o       = {FLUSH_N{flush_req}};
    assign fwd_a_o       = s_fwd[0];
    assign fwd_b_o       = s_fwd[1];
    assign rf_rd_en_o    = id_reads && !wb_live;
    assign rf_wr_en_o    = wb_live;
    assign squash_mark_o = mark;

    // R9: the ID slot after a flush is squashed, so it cannot hold the front
    p_no_hold_after_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush_o[0] |=> !hold_front_o);
endmodule

// File: tb/hzc_ctrl_bench.sv
`timescale 1ns/1ps
module hzc_ctrl_bench;
    localparam int REG_W = 8;

    logic clk = 1'b0;
    logic rst;
    logic id_valid, ex1_valid, ex2_valid, ex2_mispredict, mem1_valid, mem2_valid, wb_valid, wb_wr;
    logic [3:0] id_kind, ex1_kind, ex2_kind, mem1_kind, mem2_kind;
    logic [REG_W-1:0] id_src_a, id_src_b, ex1_dst, ex2_dst, mem1_dst, mem2_dst;
    logic hold_front_o, bubble_o, rf_rd_en_o, rf_wr_en_o;
    logic [3:0] flush_o;
    logic [1:0] fwd_a_o, fwd_b_o;
    logic [7:0] squash_mark_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [19:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    hzc_ctrl #(.REG_W(REG_W)) u_hzc_ctrl (
        .clk(clk), .rst(rst),
        .id_valid(id_valid), .id_kind(id_kind), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex1_valid(ex1_valid), .ex1_kind(ex1_kind), .ex1_dst(ex1_dst),
        .ex2_valid(ex2_valid), .ex2_kind(ex2_kind), .ex2_dst(ex2_dst), .ex2_mispredict(ex2_mispredict),
        .mem1_valid(mem1_valid), .mem1_kind(mem1_kind), .mem1_dst(mem1_dst),
        .mem2_valid(mem2_valid), .mem2_kind(mem2_kind), .mem2_dst(mem2_dst),
        .wb_valid(wb_valid), .wb_wr(wb_wr),
        .hold_front_o(hold_front_o), .bubble_o(bubble_o), .flush_o(flush_o),
        .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o),
        .rf_rd_en_o(rf_rd_en_o), .rf_wr_en_o(rf_wr_en_o), .squash_mark_o(squash_mark_o)
    );

    function automatic logic [19:0] mk(input logic h, input logic b, input logic [3:0] f,
                                       input logic [1:0] fa, input logic [1:0] fb,
                                       input logic rd, input logic wr, input logic [7:0] m);
        return {h, b, f, fa, fb, rd, wr, m};
    endfunction

    task automatic idle_inputs();
        id_valid = 0; id_kind = 0; id_src_a = 0; id_src_b = 0;
        ex1_valid = 0; ex1_kind = 0; ex1_dst = 0;
        ex2_valid = 0; ex2_kind = 0; ex2_dst = 0; ex2_mispredict = 0;
        mem1_valid = 0; mem1_kind = 0; mem1_dst = 0;
        mem2_valid = 0; mem2_kind = 0; mem2_dst = 0;
        wb_valid = 0; wb_wr = 0;
    endtask

    // driver side of the scoreboard: queue the expectation, advance one cycle
    task automatic step(input logic [19:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    // monitor side: pop and compare mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                logic [19:0] e;
                logic [19:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {hold_front_o, bubble_o, flush_o, fwd_a_o, fwd_b_o, rf_rd_en_o, rf_wr_en_o, squash_mark_o};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h (hold,bubble,flush,fa,fb,rd,wr,marks)", t, a, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        step(mk(0,0,4'h0,0,0,0,0,8'h00), "R1");
        rst = 1'b0;
        step(mk(0,0,4'h0,0,0,0,0,8'h00), "R1");

        // R2: port conflict, ID reads
        idle_inputs(); id_valid = 1; id_kind = 1; id_src_a = 5; id_src_b = 6; wb_valid = 1; wb_wr = 1;
        step(mk(1,1,4'h0,0,0,0,1,8'h00), "R2");
        // R2: ID reads nothing (jump)
        idle_inputs(); id_valid = 1; id_kind = 6; id_src_a = 5; id_src_b = 6; wb_valid = 1; wb_wr = 1;
        step(mk(0,0,4'h0,0,0,0,1,8'h00), "R2");
        // R3: EX1 producer
        idle_inputs(); id_valid = 1; id_kind = 1; id_src_a = 5; id_src_b = 8'hFF;
        ex1_valid = 1; ex1_kind = 2; ex1_dst = 5;
        step(mk(1,1,4'h0,0,0,1,0,8'h00), "R3");
        // R4: load in EX2
        idle_inputs(); id_valid = 1; id_kind = 4; id_src_a = 3; id_src_b = 7;
        ex2_valid = 1; ex2_kind = 3; ex2_dst = 7;
        step(mk(1,1,4'h0,0,0,1,0,8'h00), "R4");
        // R4: non-load in EX2 forwards
        ex2_kind = 1;
        step(mk(0,0,4'h0,0,1,1,0,8'h00), "R4");
        // R5: load in MEM1
        idle_inputs(); id_valid = 1; id_kind = 4; id_src_a = 3; id_src_b = 7;
        mem1_valid = 1; mem1_kind = 3; mem1_dst = 3;
        step(mk(1,1,4'h0,0,0,1,0,8'h00), "R5");
        // R5: MEM1 non-load and MEM2 load forward from MEM2/WB
        mem1_kind = 2; mem2_valid = 1; mem2_kind = 3; mem2_dst = 7;
        step(mk(0,0,4'h0,2,2,1,0,8'h00), "R5");
        // R6: EX2 match wins over MEM1/MEM2
        idle_inputs(); id_valid = 1; id_kind = 1; id_src_a = 9; id_src_b = 9;
        ex2_valid = 1; ex2_kind = 1; ex2_dst = 9;
        mem1_valid = 1; mem1_kind = 1; mem1_dst = 9;
        mem2_valid = 1; mem2_kind = 1; mem2_dst = 9;
        step(mk(0,0,4'h0,1,1,1,0,8'h00), "R6");
        // R7: register 255 everywhere
        idle_inputs(); id_valid = 1; id_kind = 1; id_src_a = 8'hFF; id_src_b = 8'hFF;
        ex1_valid = 1; ex1_kind = 1; ex1_dst = 8'hFF; wb_valid = 1; wb_wr = 1;
        step(mk(0,0,4'h0,0,0,0,1,8'h00), "R7");
        // R8: unread source B, non-writing store producer
        idle_inputs(); id_valid = 1; id_kind = 2; id_src_a = 1; id_src_b = 4;
        ex1_valid = 1; ex1_kind = 1; ex1_dst = 4;
        ex2_valid = 1; ex2_kind = 4; ex2_dst = 1;
        step(mk(0,0,4'h0,0,0,1,0,8'h00), "R8");
        // R11: invalid ID, then invalid producer
        idle_inputs(); id_valid = 0; id_kind = 1; id_src_a = 5;
        ex1_valid = 1; ex1_kind = 1; ex1_dst = 5;
        step(mk(0,0,4'h0,0,0,0,0,8'h00), "R11");
        id_valid = 1; ex1_valid = 0;
        step(mk(0,0,4'h0,0,0,1,0,8'h00), "R11");
        // R9: flush overrides a hazard
        idle_inputs(); id_valid = 1; id_kind = 1; id_src_a = 5; id_src_b = 8'hFF;
        ex1_valid = 1; ex1_kind = 1; ex1_dst = 5;
        ex2_valid = 1; ex2_kind = 5; ex2_mispredict = 1;
        step(mk(0,0,4'hF,0,0,1,0,8'h00), "R9");
        // R10: squashed ID and EX2 ignored
        step(mk(0,0,4'h0,0,0,0,0,8'h1E), "R10");
        idle_inputs();
        step(mk(0,0,4'h0,0,0,0,0,8'h3C), "R10");
        step(mk(0,0,4'h0,0,0,0,0,8'h78), "R10");
        wb_valid = 1; wb_wr = 1;
        step(mk(0,0,4'h0,0,0,0,0,8'hF0), "R10");
        idle_inputs();
        step(mk(0,0,4'h0,0,0,0,0,8'hE0), "R10");
        step(mk(0,0,4'h0,0,0,0,0,8'hC0), "R10");
        wb_valid = 1; wb_wr = 1;
        step(mk(0,0,4'h0,0,0,0,0,8'h80), "R10");
        step(mk(0,0,4'h0,0,0,0,1,8'h00), "R10");
        idle_inputs();
        @(negedge clk);
        #6;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule